// File: doc/BRIEF.md
# Per-Channel Chopping Current Regulator

This block regulates current in each bridge with fixed-frequency chopping. A shared chop tick starts every chopping period. For each channel, a synchronized comparator bit reports whether the coil current has reached its set-point. From the tick and the comparator, the block picks the bridge action for every clock cycle: drive current into the coil (charge), recirculate it (slow decay), return it to the supply (fast decay), or switch the bridge off.

A 2-bit selector picks the decay style: slow, fast or mixed. The selector is read only when a tick is accepted. Every period opens with a blanking window of fixed length. During blanking the bridge charges no matter what the comparator says. In mixed decay the comparator is still watched during blanking. If the current was below the set-point at any sampled edge of the window, the bridge keeps charging until the threshold is reached, then slow-decays, then fast-decays for a fixed tail at the end of the nominal period. If the current was never below the set-point, the bridge fast-decays for the rest of the period. A disable input (standby, output off or fault) turns all bridges off at once and holds the channels idle until a tick arrives after the disable is released.

Top module: `chop_regulator`

## Requirements
- R1: After reset, every channel reports OFF (code 2'b00) until the first accepted tick. The stored decay style after reset is mixed.
- R2: When `chop_tick` is high and `drive_off` is low at a clock edge, every channel reports CHARGE (code 2'b01) in the next cycle, whatever state it was in before. That cycle is cycle 0 of a new period.
- R3: In cycles 0 to BLANK_CYC-1 of a period, a running channel reports CHARGE whatever its comparator bit is.
- R4: With slow style (`decay_sel` = 2'b01 at the tick), a channel stays in CHARGE from the edge ending cycle BLANK_CYC-1 onward until an edge samples its comparator high. From the next cycle it reports SLOW (code 2'b10) until the next tick.
- R5: With fast style (`decay_sel` = 2'b10 at the tick), the rule of R4 applies, but the decay state is FAST (code 2'b11).
- R6: With mixed style (`decay_sel` = 2'b00 or 2'b11 at the tick), a channel whose comparator was low at any edge ending cycles 0 to BLANK_CYC-1 keeps charging until its comparator is sampled high, then reports SLOW.
- R7: With mixed style, a channel that is past blanking and in CHARGE or SLOW reports FAST from cycle PERIOD_CYC-TAIL_CYC of the period onward.
- R8: With mixed style, a channel whose comparator was high at every edge ending cycles 0 to BLANK_CYC-1 reports FAST from cycle BLANK_CYC onward.
- R9: `decay_sel` is sampled only at an accepted tick. Changing it at any other time has no effect on the current period.
- R10: While `drive_off` is high, every channel reports OFF in the same cycle and ticks are ignored. After release, channels stay OFF until the next tick.
- R11: Each channel follows only its own comparator bit. Channel i uses `cmp_hit[i]` and reports in `bridge_state[2i+1:2i]`.
- R12: If no tick arrives, a channel in a decay state keeps that state past PERIOD_CYC cycles. The cycle count saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chop_tick | input | 1 | One-cycle pulse that starts a chopping period |
| drive_off | input | 1 | Standby / output-off / fault; forces all bridges OFF |
| decay_sel | input | 2 | Decay style: 01 slow, 10 fast, 00 or 11 mixed |
| cmp_hit | input | NUM_CH | Per-channel comparator, high when the coil current is at or above the set-point |
| bridge_state | output | 2*NUM_CH | Per-channel bridge action: 00 OFF, 01 CHARGE, 10 SLOW, 11 FAST |

## Verification
The hardest path to reach is the mixed-style tail after slow decay. To get there, the comparator must dip below the set-point inside blanking, then rise before the tail starts, and the period must run its full nominal length with no early tick. The stimulus builds each period from a per-channel threshold cycle, plus an optional one-cycle dip in mid-blanking. Directed periods place the dip on a comparator that is otherwise always high, and place the threshold both before and after the tail start. Random periods mix these with early ticks, overrun periods, a scrambled selector between ticks, and disable windows that cover a tick.

// File: rtl/chop_pkg.sv
// Shared types for the chopping regulator: bridge action codes, decay style
// codes and the selector decode. Assumes a 2-bit selector whose idle value
// (both bits equal) must map to the mixed style.
package chop_pkg;

    typedef enum logic [1:0] {
        BR_OFF    = 2'b00,
        BR_CHARGE = 2'b01,
        BR_SLOW   = 2'b10,
        BR_FAST   = 2'b11
    } bridge_e;

    typedef enum logic [1:0] {
        DM_MIXED = 2'b00,
        DM_SLOW  = 2'b01,
        DM_FAST  = 2'b10
    } decay_e;

    // Map the raw selector to a decay style; both idle codes give mixed.
    function automatic decay_e decode_sel(input logic [1:0] sel);
        decay_e m;
        case (sel)
            2'b01:   m = DM_SLOW;
            2'b10:   m = DM_FAST;
            default: m = DM_MIXED;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/chop_mode_latch.sv
// Holds the decay style for the current chopping period. The selector is
// sampled only when a tick is accepted, so the style is constant for the
// whole period. Assumes accept is already qualified by the disable input.
module chop_mode_latch
    import chop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic [1:0] decay_sel,
    output decay_e     mode_q
);

    // Capture the decoded style at each accepted tick; reset to mixed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= DM_MIXED;
        end else if (accept) begin
            mode_q <= decode_sel(decay_sel);
        end
    end

endmodule

// File: rtl/chop_phase_timer.sv
// Counts the cycles since the last accepted tick. It flags the blanking
// window (no comparator action yet) and the fast-tail window, both as seen
// at the edge ending the current cycle. Saturates at PERIOD_CYC so a late
// tick never wraps the count. Assumes 1 <= BLANK_CYC <= PERIOD_CYC-TAIL_CYC.
module chop_phase_timer #(
    parameter int PERIOD_CYC = 100,
    parameter int BLANK_CYC  = 10,
    parameter int TAIL_CYC   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic blank_open,
    output logic tail_due
);

    localparam int CNT_W      = $clog2(PERIOD_CYC + 1);
    localparam int TAIL_START = PERIOD_CYC - TAIL_CYC;
    localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(PERIOD_CYC);
    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_EDGE  = CNT_W'(TAIL_START - 1);

    logic [CNT_W-1:0] cnt_q;

    // Cycle counter: cleared by a tick, saturating at the nominal period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MAX;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Window flags decoded from the count for the edge ending this cycle.
    always_comb begin
        blank_open = (cnt_q < BLANK_LAST);
        tail_due   = (cnt_q >= TAIL_EDGE);
    end

endmodule

// File: rtl/chop_channel_fsm.sv
// One channel's bridge sequencer. A tick forces CHARGE. Blanking keeps
// CHARGE and, for mixed style, records whether the comparator was ever low.
// After blanking, the style decides between slow, fast and mixed sequencing.
// Decay states hold until the next tick. Assumes cmp_hit is synchronous.
module chop_channel_fsm
    import chop_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold_off,
    input  logic    restart,
    input  logic    cmp_hit,
    input  decay_e  mode,
    input  logic    blank_open,
    input  logic    tail_due,
    output bridge_e state_q
);

    bridge_e state_d;
    logic    below_q;
    logic    below_d;
    logic    below_now;

    // Next-state selection for the bridge sequence of this channel.
    always_comb begin
        state_d   = state_q;
        below_d   = below_q;
        below_now = below_q | ~cmp_hit;
        if (hold_off) begin
            state_d = BR_OFF;
            below_d = 1'b0;
        end else if (restart) begin
            state_d = BR_CHARGE;
            below_d = 1'b0;
        end else begin
            unique case (state_q)
                BR_CHARGE: begin
                    if (blank_open) begin
                        below_d = below_now;
                    end else begin
                        unique case (mode)
                            DM_SLOW: begin
                                if (cmp_hit) state_d = BR_SLOW;
                            end
                            DM_FAST: begin
                                if (cmp_hit) state_d = BR_FAST;
                            end
                            default: begin
                                below_d = below_now;
                                if (!below_now || tail_due) begin
                                    state_d = BR_FAST;
                                end else if (cmp_hit) begin
                                    state_d = BR_SLOW;
                                end
                            end
                        endcase
                    end
                end
                BR_SLOW: begin
                    if (mode == DM_MIXED && tail_due) state_d = BR_FAST;
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    // State and below-set-point flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BR_OFF;
            below_q <= 1'b0;
        end else begin
            state_q <= state_d;
            below_q <= below_d;
        end
    end

endmodule

// File: rtl/chop_regulator.sv
// Top of the chopping regulator. One phase timer and one style latch are
// shared, because all channels chop on the same tick. There is one sequencer
// per channel. The disable input overrides every output at once and keeps
// the sequencers idle. Assumes chop_tick is a single-cycle pulse.
module chop_regulator
    import chop_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int PERIOD_CYC = 100,
    parameter int BLANK_CYC  = 10,
    parameter int TAIL_CYC   = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chop_tick,
    input  logic                  drive_off,
    input  logic [1:0]            decay_sel,
    input  logic [NUM_CH-1:0]     cmp_hit,
    output logic [2*NUM_CH-1:0]   bridge_state
);

    logic    tick_ok;
    logic    blank_open;
    logic    tail_due;
    decay_e  mode_q;
    bridge_e ch_state [NUM_CH];

    // A tick counts only while the bridges are enabled.
    always_comb tick_ok = chop_tick & ~drive_off;

    chop_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (tick_ok),
        .decay_sel (decay_sel),
        .mode_q    (mode_q)
    );

    chop_phase_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .BLANK_CYC  (BLANK_CYC),
        .TAIL_CYC   (TAIL_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (tick_ok),
        .blank_open (blank_open),
        .tail_due   (tail_due)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chop_channel_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold_off   (drive_off),
            .restart    (tick_ok),
            .cmp_hit    (cmp_hit[i]),
            .mode       (mode_q),
            .blank_open (blank_open),
            .tail_due   (tail_due),
            .state_q    (ch_state[i])
        );
        // Output override: disable wins over the registered state.
        assign bridge_state[2*i+1:2*i] = drive_off ? BR_OFF : ch_state[i];
    end

endmodule

// File: rtl/chop_regulator_chk.sv
// Property checker for chop_regulator, bound to every instance. It keeps
// its own cycle-since-tick counter, so the blanking window is checked
// without any deep $past.
module chop_regulator_chk #(
    parameter int NUM_CH     = 2,
    parameter int PERIOD_CYC = 100,
    parameter int BLANK_CYC  = 10,
    parameter int TAIL_CYC   = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chop_tick,
    input logic                drive_off,
    input logic [2*NUM_CH-1:0] bridge_state
);

    int unsigned since_q;

    // Independent count of cycles since the last accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= PERIOD_CYC;
        end else if (chop_tick && !drive_off) begin
            since_q <= 0;
        end else if (since_q < PERIOD_CYC) begin
            since_q <= since_q + 1;
        end
    end

    // R10: disable turns every bridge off in the same cycle.
    a_r10_off_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        drive_off |-> (bridge_state == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R2: an accepted tick yields CHARGE next cycle unless disabled.
        a_r2_tick_starts_charge: assert property (@(posedge clk) disable iff (!rst_n)
            (chop_tick && !drive_off) |=> (drive_off || bridge_state[2*i+1:2*i] == 2'b01));
        // R3: a running channel charges throughout blanking.
        a_r3_blank_holds_charge: assert property (@(posedge clk) disable iff (!rst_n)
            (!drive_off && since_q < BLANK_CYC && bridge_state[2*i+1:2*i] != 2'b00)
            |-> (bridge_state[2*i+1:2*i] == 2'b01));
        // R10: an idle channel leaves OFF only through a tick.
        a_r10_idle_until_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (bridge_state[2*i+1:2*i] == 2'b00 && !chop_tick)
            |=> (drive_off || bridge_state[2*i+1:2*i] == 2'b00));
        // R12: fast decay persists until a tick or a disable.
        a_r12_fast_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (bridge_state[2*i+1:2*i] == 2'b11 && !chop_tick && !drive_off)
            |=> (drive_off || bridge_state[2*i+1:2*i] == 2'b11));
    end

endmodule

bind chop_regulator chop_regulator_chk #(
    .NUM_CH     (NUM_CH),
    .PERIOD_CYC (PERIOD_CYC),
    .BLANK_CYC  (BLANK_CYC),
    .TAIL_CYC   (TAIL_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chop_tick    (chop_tick),
    .drive_off    (drive_off),
    .bridge_state (bridge_state)
);

// File: tb/chop_regulator_test.sv
// Self-checking bench: a cycle model built from the requirements, with
// directed periods and seeded random periods.
module chop_regulator_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int PER        = 100;
    localparam int BLK        = 10;
    localparam int TAIL       = 10;
    localparam int TSTART     = PER - TAIL;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chop_tick = 1'b0;
    logic             drive_off = 1'b0;
    logic [1:0]       decay_sel = 2'b00;
    logic [NCH-1:0]   cmp_hit = '0;
    logic [2*NCH-1:0] bridge_state;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    bit scramble = 0;

    // Model state.
    logic [1:0] m_st [NCH];
    bit         m_seen [NCH];
    int         m_k = PER;
    logic [1:0] m_mode = 2'd0;

    chop_regulator #(
        .NUM_CH (NCH), .PERIOD_CYC (PER), .BLANK_CYC (BLK), .TAIL_CYC (TAIL)
    ) uut (
        .clk (clk), .rst_n (rst_n), .chop_tick (chop_tick), .drive_off (drive_off),
        .decay_sel (decay_sel), .cmp_hit (cmp_hit), .bridge_state (bridge_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] style_of(input logic [1:0] s);
        return (s == 2'b01) ? 2'd1 : (s == 2'b10) ? 2'd2 : 2'd0;
    endfunction

    // Reference model, advanced at each edge from the requirement text.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin m_st[c] = 2'd0; m_seen[c] = 0; end
            m_k = PER; m_mode = 2'd0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (drive_off) begin
                    m_st[c] = 2'd0; m_seen[c] = 0;
                end else if (chop_tick) begin
                    m_st[c] = 2'd1; m_seen[c] = 0;
                end else if (m_st[c] == 2'd1) begin
                    if (m_k + 1 < BLK) begin
                        if (!cmp_hit[c]) m_seen[c] = 1;
                    end else if (m_mode == 2'd1) begin
                        if (cmp_hit[c]) m_st[c] = 2'd2;
                    end else if (m_mode == 2'd2) begin
                        if (cmp_hit[c]) m_st[c] = 2'd3;
                    end else begin
                        if (!cmp_hit[c]) m_seen[c] = 1;
                        if (!m_seen[c] || m_k + 1 >= TSTART) m_st[c] = 2'd3;
                        else if (cmp_hit[c]) m_st[c] = 2'd2;
                    end
                end else if (m_st[c] == 2'd2 && m_mode == 2'd0 && m_k + 1 >= TSTART) begin
                    m_st[c] = 2'd3;
                end
            end
            if (chop_tick && !drive_off) begin
                m_mode = style_of(decay_sel);
                m_k = 0;
            end else if (m_k < PER) begin
                m_k = m_k + 1;
            end
        end
    end

    task automatic chk(input string req, input int ch, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d k=%0d: actual %0d expected %0d", req, ch, m_k, act, exp);
        end
    endtask

    function automatic string tag_of(input int c, input logic [1:0] exp);
        if (scramble) return "R9";
        if (exp == 2'd0) return drive_off ? "R10" : "R1";
        if (m_k == 0) return "R2";
        if (m_k < BLK) return "R3";
        if (m_k >= PER) return "R12";
        if (m_st[0] != m_st[1]) return "R11";
        if (m_mode == 2'd1) return "R4";
        if (m_mode == 2'd2) return "R5";
        if (exp == 2'd3) return (m_k >= TSTART) ? "R7" : (m_seen[c] ? "R6" : "R8");
        return "R6";
    endfunction

    // Compare every channel with the model for the current cycle.
    task automatic check_all();
        for (int c = 0; c < NCH; c++) begin
            logic [1:0] exp;
            exp = drive_off ? 2'd0 : m_st[c];
            chk(tag_of(c, exp), c, bridge_state[2*c +: 2], exp);
        end
    endtask

    int thr [NCH];
    bit dip [NCH];

    // One period: cmp[c] goes high from cycle thr[c]; an optional dip pulls
    // it low in mid-blanking; the tick ends the period at cycle len-1.
    task automatic run_period(input logic [1:0] sel, input int len,
                              input int off_from, input int off_to, input bit scr);
        scramble = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            check_all();
            scramble = scr && k > 0;
            for (int c = 0; c < NCH; c++)
                cmp_hit[c] = (dip[c] && k == BLK/2) ? 1'b0 : (k >= thr[c]);
            chop_tick = (k == len - 1);
            drive_off = (k >= off_from && k < off_to);
            decay_sel = (scr && !chop_tick) ? 2'($urandom) : sel;
            if (drive_off) begin
                #1;
                chk("R10", 0, 2'(bridge_state == '0), 2'd1);
            end
        end
        scramble = 0;
    endtask

    task automatic set_ch(input int t0, input bit d0, input int t1, input bit d1);
        thr[0] = t0; dip[0] = d0; thr[1] = t1; dip[1] = d1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c40f));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 0, bridge_state[1:0], 2'd0);
        chk("R1", 1, bridge_state[3:2], 2'd0);
        // Idle before the first tick, then start.
        set_ch(0, 0, 0, 0);
        run_period(2'b00, 6, -1, -1, 0);
        // R4 slow, R5 fast, with channels reaching threshold at different cycles (R11).
        set_ch(20, 0, 40, 0);  run_period(2'b01, PER, -1, -1, 0);
        set_ch(15, 0, 60, 0);  run_period(2'b10, PER, -1, -1, 0);
        // R6/R7 below-seen then tail; R8 never below on ch0, dip-only on ch1.
        set_ch(30, 0, 0, 1);   run_period(2'b00, PER, -1, -1, 0);
        set_ch(0, 0, 0, 1);    run_period(2'b11, PER, -1, -1, 0);
        set_ch(95, 0, 50, 0);  run_period(2'b00, PER, -1, -1, 0);
        // R9 selector scrambled between ticks.
        set_ch(25, 0, 0, 0);   run_period(2'b01, PER, -1, -1, 1);
        set_ch(25, 1, 0, 1);   run_period(2'b10, PER, -1, -1, 1);
        // R2 early restart mid-decay; R12 overrun.
        set_ch(12, 0, 20, 0);  run_period(2'b01, 40, -1, -1, 0);
        set_ch(12, 0, 0, 0);   run_period(2'b10, 160, -1, -1, 0);
        // R10 disable mid-period, and across a tick.
        set_ch(20, 0, 30, 0);  run_period(2'b01, PER, 50, 60, 0);
        set_ch(20, 0, 30, 0);  run_period(2'b00, PER, PER - 3, PER + 5, 0);
        set_ch(20, 0, 30, 0);  run_period(2'b00, PER, -1, -1, 0);
        // Seeded random periods.
        for (int p = 0; p < 150; p++) begin
            int len, ofs;
            len = 20 + int'($urandom_range(0, 140));
            set_ch(int'($urandom_range(0, 110)), bit'($urandom), int'($urandom_range(0, 110)), bit'($urandom));
            ofs = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, len)) : -1;
            run_period(2'($urandom), len, ofs, ofs + int'($urandom_range(1, 8)), bit'($urandom_range(0, 5) == 0));
        end
        @(negedge clk);
        check_all();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule